// File: doc/BRIEF.md
# Flash write guard with block protection

This block decides whether a request that changes a serial flash device may start. It holds the 8-bit status byte, including the write enable latch, the busy flag, the three protection-level bits and the status-write lock bit. A command engine sends it a one-cycle request strobe when chip select rises at a clean byte boundary. The strobe carries a 3-bit request code, the 24-bit target address and, for a status write, the new status value. One cycle later the block answers with exactly one of two pulses: go or refuse. An accepted modifying request also gives a launch pulse and the code for the self-timed cycle controller. That controller reports completion on a done input.

The protection bits select a region that grows downward from the top of the array, measured in 64 KiB blocks. The address bits just above the block offset choose the block. A status-write lock bit together with a low write-protect pin freezes the status byte, so it can be changed again only after the pin is driven high.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset the status byte reads 0x1C. Bit 7 is the lock bit = 0, bits 6:5 = 0, bits 4:2 are the level bits = 111, bit 1 is the write enable latch = 0, bit 0 is busy = 0.
- R2: Request code 1 sets the write enable latch and code 2 clears it. Each is answered with go one cycle after the strobe when busy is 0. While busy is 1, either code is refused and has no effect.
- R3: A modifying request (code 3 status write, 4 page program, 5 sector erase, 6 block erase, 7 chip erase) that arrives with the latch at 0 or busy at 1 is refused, gives no launch, and leaves the status byte unchanged. Code 0 is always refused.
- R4: Page program, sector erase and block erase are refused when address bits 18:16 name a protected block. The protected blocks by level are: 000 none; 001 block 7; 010 blocks 6-7; 011 blocks 4-7; any level with bit 4 set protects all blocks.
- R5: Chip erase is accepted only when the level bits are 000.
- R6: An accepted modifying request sets busy in the same cycle as the launch pulse, and both are visible one cycle after the strobe. Busy stays at 1 until done is seen. Busy and the latch then both read 0 one cycle later. Done while busy is 0 is ignored.
- R7: A status write takes only bits 7 and 4:2 from the written value. These bits change when the cycle completes. Bits 6:5 stay at 0, and bits 1:0 follow only their own rules.
- R8: While the lock bit is 1 and the write-protect pin is low, a status write is refused even when the latch is set. With the pin high, the same request is accepted.
- R9: Every strobe is answered, one cycle later, by exactly one of go or refuse. An accepted modifying request reports its request code on the cycle-code output during the launch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Request code (0 none, 1 set latch, 2 clear latch, 3 status write, 4 program, 5 sector erase, 6 block erase, 7 chip erase) |
| req_addr | input | 24 | Target byte address |
| req_sdata | input | 8 | New status value for a status write |
| wp_n | input | 1 | Write-protect pin level, low active |
| cyc_done | input | 1 | Self-timed cycle finished |
| status | output | 8 | Status byte |
| req_go | output | 1 | Request accepted |
| req_rej | output | 1 | Request refused |
| cyc_launch | output | 1 | Start pulse for the self-timed cycle |
| cyc_op | output | 3 | Code of the launched cycle |

## Verification
The hardest state to reach from the ports is the hardware lock. The bench must first raise the latch and complete a status write that sets the lock bit. Only after that can it drop the write-protect pin and try another status write. Each protection level also has to be installed through such a completed write before its block boundaries can be probed. Directed sequences therefore walk all eight levels across all eight blocks and enter and leave the lock. Seeded random requests follow, with random done pulses and pin levels, so that strobes land on busy cycles and collide with completion.

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
  parameter int ADDR_W  = 24,
  parameter int BLK_LSB = 16,
  parameter int BLK_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_sdata,
  input  logic              wp_n,
  input  logic              cyc_done,
  output logic [7:0]        status,
  output logic              req_go,
  output logic              req_rej,
  output logic              cyc_launch,
  output logic [2:0]        cyc_op
);
  localparam int NBLK = 1 << BLK_W;
  localparam logic [2:0] OP_SET = 3'd1, OP_CLR = 3'd2, OP_WRSR = 3'd3,
                         OP_PP = 3'd4, OP_SE = 3'd5, OP_BE = 3'd6, OP_CE = 3'd7;

  logic       lock_q, wel_q, wip_q, pend_sr_q;
  logic [2:0] lvl_q;
  logic [3:0] pend_q;
  logic [BLK_W-1:0] blk;
  logic hw_lock, in_prot, is_mod, ok;

  assign blk     = req_addr[BLK_LSB +: BLK_W];
  assign hw_lock = lock_q & ~wp_n;
  assign is_mod  = req_op >= OP_WRSR;
  assign status  = {lock_q, 2'b00, lvl_q, wel_q, wip_q};

  function automatic logic covers(input logic [2:0] lvl, input logic [BLK_W-1:0] b);
    int span;
    if (lvl == 3'd0) return 1'b0;
    if (int'(lvl) - 1 >= BLK_W) return 1'b1;
    span = 1 << (int'(lvl) - 1);
    return int'(b) >= NBLK - span;
  endfunction

  assign in_prot = covers(lvl_q, blk);

  always_comb begin
    case (req_op)
      OP_SET, OP_CLR:     ok = ~wip_q;
      OP_WRSR:            ok = wel_q & ~wip_q & ~hw_lock;
      OP_PP, OP_SE, OP_BE: ok = wel_q & ~wip_q & ~in_prot;
      OP_CE:              ok = wel_q & ~wip_q & (lvl_q == 3'd0);
      default:            ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lvl_q      <= 3'b111;
      wel_q      <= 1'b0;
      wip_q      <= 1'b0;
      pend_sr_q  <= 1'b0;
      pend_q     <= '0;
      req_go     <= 1'b0;
      req_rej    <= 1'b0;
      cyc_launch <= 1'b0;
      cyc_op     <= '0;
    end else begin
      req_go     <= req_valid & ok;
      req_rej    <= req_valid & ~ok;
      cyc_launch <= req_valid & ok & is_mod;
      if (wip_q && cyc_done) begin
        wip_q     <= 1'b0;
        wel_q     <= 1'b0;
        pend_sr_q <= 1'b0;
        if (pend_sr_q) begin
          lock_q <= pend_q[3];
          lvl_q  <= pend_q[2:0];
        end
      end
      if (req_valid && ok) begin
        case (req_op)
          OP_SET: wel_q <= 1'b1;
          OP_CLR: wel_q <= 1'b0;
          default: begin
            wip_q     <= 1'b1;
            cyc_op    <= req_op;
            pend_sr_q <= (req_op == OP_WRSR);
            pend_q    <= {req_sdata[7], req_sdata[4:2]};
          end
        endcase
      end
    end
  end
endmodule

module flash_wr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       req_go,
  input logic       req_rej,
  input logic       cyc_launch,
  input logic [2:0] cyc_op
);
  p_launch_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_launch |-> ($past(status[1]) && !$past(status[0])));
  p_busy_with_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_launch |-> status[0]);
  p_wel_drops_with_wip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);
  p_ce_needs_zero_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_launch && cyc_op == 3'd7) |-> ($past(status[4:2]) == 3'b000));
  p_prot_bits_move_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(status[0]) |-> $stable({status[7], status[4:2]}));
  p_no_wrsr_in_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_launch && cyc_op == 3'd3) |-> !($past(status[7]) && !$past(wp_n)));
  p_single_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_go && req_rej));
  p_every_strobe_answered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (req_go || req_rej));
endmodule

bind flash_wr_guard flash_wr_guard_chk u_chk (.*);

// File: tb/flash_wr_guard_bench.sv
module flash_wr_guard_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wp_n = 1'b1, cyc_done = 1'b0;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_sdata = '0;
  logic [7:0] status;
  logic req_go, req_rej, cyc_launch;
  logic [2:0] cyc_op;

  int total = 0, bad = 0;
  bit m_lock, m_wel, m_wip, m_psr;
  bit [2:0] m_lvl;
  bit [3:0] m_pend;

  flash_wr_guard u_flash_wr_guard (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit f_prot(bit [2:0] lvl, bit [2:0] b);
    if (lvl == 0) return 0;
    if (lvl[2]) return 1;
    return int'(b) >= 8 - (1 << (int'(lvl) - 1));
  endfunction

  function automatic bit f_ok(bit [2:0] op, bit [23:0] a, bit w);
    case (op)
      3'd1, 3'd2: return !m_wip;
      3'd3: return m_wel && !m_wip && !(m_lock && !w);
      3'd4, 3'd5, 3'd6: return m_wel && !m_wip && !f_prot(m_lvl, a[18:16]);
      3'd7: return m_wel && !m_wip && m_lvl == 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit [7:0] f_status();
    return {m_lock, 2'b00, m_lvl, m_wel, m_wip};
  endfunction

  task automatic step(bit v, bit [2:0] op, bit [23:0] a, bit [7:0] d, bit dn, bit w, string tag);
    bit ok;
    ok = v && f_ok(op, a, w);
    req_valid = v; req_op = op; req_addr = a; req_sdata = d; cyc_done = dn; wp_n = w;
    @(posedge clk); @(negedge clk);
    if (m_wip && dn) begin
      m_wip = 0; m_wel = 0;
      if (m_psr) begin m_lock = m_pend[3]; m_lvl = m_pend[2:0]; end
      m_psr = 0;
    end
    if (ok) begin
      if (op == 3'd1) m_wel = 1;
      else if (op == 3'd2) m_wel = 0;
      else begin m_wip = 1; m_psr = (op == 3'd3); m_pend = {d[7], d[4:2]}; end
    end
    check({tag, " go"}, req_go, ok);
    check({tag, " refuse"}, req_rej, v && !ok);
    check({tag, " launch"}, cyc_launch, ok && op >= 3);
    check({tag, " status"}, status, f_status());
    if (ok && op >= 3) check({tag, " cycle code"}, cyc_op, op);
    req_valid = 0; cyc_done = 0;
  endtask

  task automatic set_level(bit [2:0] lvl, bit lk);
    step(1, 3'd1, 0, 0, 0, 1, "R2 set latch");
    step(1, 3'd3, 0, {lk, 2'b11, lvl, 2'b11}, 0, 1, "R7 status write");
    step(0, 0, 0, 0, 1, 1, "R6 done");
  endtask

  initial begin
    m_lock = 0; m_wel = 0; m_wip = 0; m_psr = 0; m_lvl = 3'b111; m_pend = 0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status, 8'h1C);
    check("R1 reset outputs", {req_go, req_rej, cyc_launch}, 3'b000);

    step(1, 3'd3, 0, 8'h00, 0, 1, "R3 status write without latch");
    step(1, 3'd0, 0, 8'h00, 0, 1, "R3 code zero");
    step(1, 3'd1, 0, 0, 0, 1, "R2 set latch");
    step(1, 3'd2, 0, 0, 0, 1, "R2 clear latch");
    step(1, 3'd4, 24'h000100, 0, 0, 1, "R4 program all protected");
    step(0, 0, 0, 0, 1, 1, "R6 done while idle");

    set_level(3'b111, 1);
    check("R7 lock and level", status, 8'h9C);
    step(1, 3'd1, 0, 0, 0, 0, "R8 latch under lock");
    step(1, 3'd3, 0, 8'h00, 0, 0, "R8 status write in lock");
    step(1, 3'd3, 0, 8'h63, 0, 1, "R8 status write pin high");
    step(1, 3'd1, 0, 0, 0, 1, "R2 latch while busy");
    step(1, 3'd4, 0, 0, 0, 1, "R3 program while busy");
    step(0, 0, 0, 0, 1, 1, "R6 done");
    check("R7 masked bits", status, 8'h00);

    for (int lvl = 0; lvl < 8; lvl++) begin
      set_level(lvl[2:0], 0);
      for (int b = 0; b < 8; b++) begin
        step(1, 3'd1, 0, 0, 0, 1, "R2 set latch");
        step(1, 3'(4 + b % 3), {5'd0, b[2:0], 16'h0A50}, 0, 0, 1, "R4 block check");
        step(0, 0, 0, 0, 1, 1, "R6 done");
      end
      step(1, 3'd1, 0, 0, 0, 1, "R2 set latch");
      step(1, 3'd7, 0, 0, 0, 1, "R5 chip erase");
      step(0, 0, 0, 0, 1, 1, "R6 done");
      step(1, 3'd2, 0, 0, 0, 1, "R2 clear latch");
    end

    for (int i = 0; i < 1500; i++) begin
      bit [2:0] op;
      op = ($urandom % 4 == 0) ? 3'd1 : 3'($urandom);
      step($urandom % 3 != 0, op, 24'($urandom), 8'($urandom), $urandom % 4 == 0,
           $urandom % 4 != 0, "R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule